// File: doc/BRIEF.md
# Repeated String Transfer Engine

This block runs one string operation over bytes or 16-bit words, either once or repeated under a count held in a count register. It keeps a source offset, a destination offset and the count. The source element sits at data segment times sixteen plus the source offset. The destination element sits at extra segment times sixteen plus the destination offset. A direction input chooses whether both offsets climb or fall after each element, by one for bytes and by two for words.

Five operations are supported:
- copy source to destination;
- compare source with destination;
- scan the destination against an accumulator;
- load the source into the accumulator;
- store the accumulator to the destination.

Two repeat forms can end early on the zero flag that compare and scan produce. One stops while elements are equal, the other while they differ.

The engine reaches memory through a single request/acknowledge port with one access in flight. When it terminates it pulses `done` and holds the final count, offsets, accumulator and zero flag on its outputs until the next start.

The controller is a Moore machine with these states:

| State | Role |
|---|---|
| ST_IDLE | Waits for `start`, which latches the operands. |
| ST_CHECK | Tests the count and the operation code. |
| ST_RD_SRC | Reads the source element. |
| ST_RD_DST | Reads the destination element. |
| ST_WR_DST | Writes the destination element. |
| ST_STEP | Moves the offsets and records the compare result. |
| ST_FIN | Pulses `done`. |

Its transitions are:
- ST_IDLE to ST_CHECK on `start`.
- ST_CHECK to ST_FIN when the code is reserved, or when a repeat meets a zero count.
- Otherwise ST_CHECK goes to the first access of the operation: ST_RD_SRC for copy, compare and load; ST_RD_DST for scan; ST_WR_DST for store.
- ST_RD_SRC moves on when its access is acknowledged: to ST_RD_DST for compare, to ST_WR_DST for copy, and to ST_STEP for load.
- ST_RD_DST and ST_WR_DST go to ST_STEP when their access is acknowledged.
- ST_STEP goes to ST_FIN when there is no repeat or when the zero-flag condition ends the run. Otherwise it goes back to ST_CHECK.
- ST_FIN goes to ST_IDLE.

Top module: `strx_engine`

## Requirements
- R1: After reset `busy`, `done` and `mem_req` are 0.
- R2: A source access uses address `ds_i*16 + si` and a destination access uses `es_i*16 + di`, both taken modulo 2^20. The offsets and the count wrap modulo 2^16.
- R3: After each element both offsets are stepped by 1 (`wide_i`=0) or 2 (`wide_i`=1), added when `dir_i`=0 and subtracted when `dir_i`=1. Copy and compare step both offsets, load steps only the source offset, and scan and store step only the destination offset.
- R4: `op_i` codes are 0 copy, 1 compare, 2 scan, 3 load and 4 store. Per element:
  - Copy reads the source and writes that value to the destination.
  - Compare reads the source, then the destination.
  - Scan reads the destination.
  - Load reads the source into the accumulator; a byte load replaces only bits 7:0.
  - Store writes the accumulator to the destination.
  - Codes 5 to 7 make no access, change no output register, and raise `done` in the second cycle after `start`.
- R5: With `rep_i`=0 exactly one element is processed and the count is left unchanged.
- R6: With `rep_i`≠0 the count is tested before each element. The run stops when the count is 0; otherwise the count is decremented and one element is processed. A zero count at start gives no memory access and `done` in the second cycle after `start`.
- R7: For compare and scan, `rep_i`=2 also stops after an element that leaves the zero flag 0, and `rep_i`=3 also stops after an element that leaves it 1.
- R8: Compare and scan set the zero flag to 1 exactly when the two elements are equal; for bytes only bits 7:0 are compared. Copy, load and store keep `zf_i`, and for them `rep_i`=2 or 3 acts as `rep_i`=1.
- R9: `mem_req` is 0 while idle. A raised request keeps its address, write enable and write data until `mem_ack`, and `mem_ack` may arrive in the same cycle. Accesses take place one at a time in the order given in R4.
- R10: `done` is high for exactly one cycle per run, only while busy. From that cycle the results on `cx_o`, `si_o`, `di_o`, `acc_o` and `zf_o` stay put until the next accepted start.
- R11: A `start` seen while `busy` is 1 is ignored.
- R12: `mem_wide` gives the access width for the whole run, and byte data travels in bits 7:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a run with the operands below |
| op_i | input | 3 | Operation code |
| rep_i | input | 2 | Repeat form: 0 none, 1 count, 2 while equal, 3 while different |
| wide_i | input | 1 | 1 word elements, 0 byte elements |
| dir_i | input | 1 | 0 offsets climb, 1 offsets fall |
| cx_i | input | OFF_W | Initial count |
| si_i | input | OFF_W | Initial source offset |
| di_i | input | OFF_W | Initial destination offset |
| ds_i | input | OFF_W | Source segment |
| es_i | input | OFF_W | Destination segment |
| acc_i | input | DATA_W | Initial accumulator |
| zf_i | input | 1 | Initial zero flag |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 write, 0 read |
| mem_wide | output | 1 | Access width, 1 word |
| mem_addr | output | OFF_W+SEG_SHIFT | Byte address |
| mem_wdata | output | DATA_W | Write data |
| mem_ack | input | 1 | Access complete, read data valid |
| mem_rdata | input | DATA_W | Read data |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| cx_o | output | OFF_W | Count |
| si_o | output | OFF_W | Source offset |
| di_o | output | OFF_W | Destination offset |
| acc_o | output | DATA_W | Accumulator |
| zf_o | output | 1 | Zero flag |

## Verification
The bench builds the engine with its defaults: 16-bit offsets, a 4-bit segment shift and 16-bit words. This makes offset wrap at 0xFFFF and address wrap past 2^20 reachable with short runs. The memory model acknowledges after 0, 1 or 2 cycles, so both the same-cycle acknowledge and held requests are covered. Every access is matched against a behavioural reference as it completes, including the early exits of both zero-flag repeat forms, a zero start count, a reserved code and a start arriving mid-run.

// File: rtl/strx_pkg.sv
package strx_pkg;

    typedef enum logic [2:0] {
        OP_MOVE  = 3'd0,
        OP_CMP   = 3'd1,
        OP_SCAN  = 3'd2,
        OP_LOAD  = 3'd3,
        OP_STORE = 3'd4
    } op_e;

    typedef enum logic [1:0] {
        REP_NONE     = 2'd0,
        REP_ALL      = 2'd1,
        REP_WHILE_EQ = 2'd2,
        REP_WHILE_NE = 2'd3
    } rep_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHECK,
        ST_RD_SRC,
        ST_RD_DST,
        ST_WR_DST,
        ST_STEP,
        ST_FIN
    } state_e;

    function automatic logic op_known(input logic [2:0] c);
        return c <= 3'd4;
    endfunction

    function automatic logic op_reads_src(input logic [2:0] c);
        return (c == OP_MOVE) || (c == OP_CMP) || (c == OP_LOAD);
    endfunction

    function automatic logic op_reads_dst(input logic [2:0] c);
        return (c == OP_CMP) || (c == OP_SCAN);
    endfunction

    function automatic logic op_steps_si(input logic [2:0] c);
        return (c == OP_MOVE) || (c == OP_CMP) || (c == OP_LOAD);
    endfunction

    function automatic logic op_steps_di(input logic [2:0] c);
        return (c == OP_MOVE) || (c == OP_CMP) || (c == OP_SCAN) || (c == OP_STORE);
    endfunction

    function automatic logic op_sets_zf(input logic [2:0] c);
        return (c == OP_CMP) || (c == OP_SCAN);
    endfunction

endpackage

// File: rtl/strx_fsm.sv
module strx_fsm
    import strx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [2:0] op,
    input  logic [1:0] rep,
    input  logic       cx_zero,
    input  logic       match,
    input  logic       mem_ack,
    output logic       busy,
    output logic       done,
    output logic       mem_req,
    output logic       mem_we,
    output logic       use_src,
    output logic       load_cfg,
    output logic       dec_cx,
    output logic       cap_src,
    output logic       cap_dst,
    output logic       step_en,
    output logic       zf_upd
);

    state_e state;
    state_e nxt;
    logic   repeating;
    logic   zf_exit;

    assign repeating = (rep != REP_NONE);
    assign zf_exit   = op_sets_zf(op) &&
                       (((rep == REP_WHILE_EQ) && !match) ||
                        ((rep == REP_WHILE_NE) &&  match));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (start) begin
                    nxt = ST_CHECK;
                end
            end
            ST_CHECK: begin
                if (!op_known(op)) begin
                    nxt = ST_FIN;
                end else if (repeating && cx_zero) begin
                    nxt = ST_FIN;
                end else if (op_reads_src(op)) begin
                    nxt = ST_RD_SRC;
                end else if (op_reads_dst(op)) begin
                    nxt = ST_RD_DST;
                end else begin
                    nxt = ST_WR_DST;
                end
            end
            ST_RD_SRC: begin
                if (mem_ack) begin
                    if (op == OP_CMP) begin
                        nxt = ST_RD_DST;
                    end else if (op == OP_MOVE) begin
                        nxt = ST_WR_DST;
                    end else begin
                        nxt = ST_STEP;
                    end
                end
            end
            ST_RD_DST: begin
                if (mem_ack) begin
                    nxt = ST_STEP;
                end
            end
            ST_WR_DST: begin
                if (mem_ack) begin
                    nxt = ST_STEP;
                end
            end
            ST_STEP: begin
                if (!repeating || zf_exit) begin
                    nxt = ST_FIN;
                end else begin
                    nxt = ST_CHECK;
                end
            end
            ST_FIN: begin
                nxt = ST_IDLE;
            end
            default: begin
                nxt = ST_IDLE;
            end
        endcase
    end

    always_comb begin
        busy     = 1'b1;
        done     = 1'b0;
        mem_req  = 1'b0;
        mem_we   = 1'b0;
        use_src  = 1'b0;
        load_cfg = 1'b0;
        dec_cx   = 1'b0;
        cap_src  = 1'b0;
        cap_dst  = 1'b0;
        step_en  = 1'b0;
        zf_upd   = 1'b0;
        unique case (state)
            ST_IDLE: begin
                busy     = 1'b0;
                load_cfg = start;
            end
            ST_CHECK: begin
                dec_cx = repeating && op_known(op) && !cx_zero;
            end
            ST_RD_SRC: begin
                mem_req = 1'b1;
                use_src = 1'b1;
                cap_src = mem_ack;
            end
            ST_RD_DST: begin
                mem_req = 1'b1;
                cap_dst = mem_ack;
            end
            ST_WR_DST: begin
                mem_req = 1'b1;
                mem_we  = 1'b1;
            end
            ST_STEP: begin
                step_en = 1'b1;
                zf_upd  = op_sets_zf(op);
            end
            ST_FIN: begin
                done = 1'b1;
            end
            default: begin
                busy = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/strx_regs.sv
module strx_regs
    import strx_pkg::*;
#(
    parameter int OFF_W  = 16,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_cfg,
    input  logic [2:0]        op_in,
    input  logic [1:0]        rep_in,
    input  logic              wide_in,
    input  logic              dir_in,
    input  logic [OFF_W-1:0]  cx_in,
    input  logic [OFF_W-1:0]  si_in,
    input  logic [OFF_W-1:0]  di_in,
    input  logic [OFF_W-1:0]  ds_in,
    input  logic [OFF_W-1:0]  es_in,
    input  logic [DATA_W-1:0] acc_in,
    input  logic              zf_in,
    input  logic              dec_cx,
    input  logic              step_en,
    input  logic              cap_src,
    input  logic              cap_dst,
    input  logic              zf_upd,
    input  logic              match,
    input  logic [DATA_W-1:0] rdata,
    output logic [2:0]        op_q,
    output logic [1:0]        rep_q,
    output logic              wide_q,
    output logic [OFF_W-1:0]  cx_q,
    output logic [OFF_W-1:0]  si_q,
    output logic [OFF_W-1:0]  di_q,
    output logic [OFF_W-1:0]  ds_q,
    output logic [OFF_W-1:0]  es_q,
    output logic [DATA_W-1:0] acc_q,
    output logic              zf_q,
    output logic [DATA_W-1:0] src_q,
    output logic [DATA_W-1:0] dst_q
);

    localparam int HALF_W = DATA_W / 2;
    localparam int N_PTR  = 2;

    logic             dir_q;
    logic [OFF_W-1:0] stride;
    logic [OFF_W-1:0] ptr_init [N_PTR];
    logic [OFF_W-1:0] ptr_val  [N_PTR];
    logic             ptr_en   [N_PTR];

    assign stride      = wide_q ? OFF_W'(2) : OFF_W'(1);
    assign ptr_init[0] = si_in;
    assign ptr_init[1] = di_in;
    assign ptr_en[0]   = step_en && op_steps_si(op_q);
    assign ptr_en[1]   = step_en && op_steps_di(op_q);
    assign si_q        = ptr_val[0];
    assign di_q        = ptr_val[1];

    for (genvar g = 0; g < N_PTR; g++) begin : g_ptr
        logic [OFF_W-1:0] ptr_r;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ptr_r <= '0;
            end else if (load_cfg) begin
                ptr_r <= ptr_init[g];
            end else if (ptr_en[g]) begin
                ptr_r <= dir_q ? (ptr_r - stride) : (ptr_r + stride);
            end
        end
        assign ptr_val[g] = ptr_r;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q   <= '0;
            rep_q  <= '0;
            wide_q <= 1'b0;
            dir_q  <= 1'b0;
            ds_q   <= '0;
            es_q   <= '0;
        end else if (load_cfg) begin
            op_q   <= op_in;
            rep_q  <= rep_in;
            wide_q <= wide_in;
            dir_q  <= dir_in;
            ds_q   <= ds_in;
            es_q   <= es_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cx_q <= '0;
        end else if (load_cfg) begin
            cx_q <= cx_in;
        end else if (dec_cx) begin
            cx_q <= cx_q - OFF_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (load_cfg) begin
            acc_q <= acc_in;
        end else if (cap_src && (op_q == OP_LOAD)) begin
            if (wide_q) begin
                acc_q <= rdata;
            end else begin
                acc_q <= {acc_q[DATA_W-1:HALF_W], rdata[HALF_W-1:0]};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            zf_q <= 1'b0;
        end else if (load_cfg) begin
            zf_q <= zf_in;
        end else if (zf_upd) begin
            zf_q <= match;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_q <= '0;
            dst_q <= '0;
        end else begin
            if (cap_src) begin
                src_q <= rdata;
            end
            if (cap_dst) begin
                dst_q <= rdata;
            end
        end
    end

endmodule

// File: rtl/strx_cmp.sv
module strx_cmp #(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] lhs,
    input  logic [DATA_W-1:0] rhs,
    input  logic              wide,
    output logic              match
);

    localparam int HALF_W = DATA_W / 2;

    logic lo_eq;
    logic hi_eq;

    assign lo_eq = (lhs[HALF_W-1:0] == rhs[HALF_W-1:0]);
    assign hi_eq = (lhs[DATA_W-1:HALF_W] == rhs[DATA_W-1:HALF_W]);
    assign match = lo_eq && (hi_eq || !wide);

endmodule

// File: rtl/strx_engine.sv
module strx_engine
    import strx_pkg::*;
#(
    parameter int OFF_W     = 16,
    parameter int SEG_SHIFT = 4,
    parameter int DATA_W    = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start,
    input  logic [2:0]                 op_i,
    input  logic [1:0]                 rep_i,
    input  logic                       wide_i,
    input  logic                       dir_i,
    input  logic [OFF_W-1:0]           cx_i,
    input  logic [OFF_W-1:0]           si_i,
    input  logic [OFF_W-1:0]           di_i,
    input  logic [OFF_W-1:0]           ds_i,
    input  logic [OFF_W-1:0]           es_i,
    input  logic [DATA_W-1:0]          acc_i,
    input  logic                       zf_i,
    output logic                       mem_req,
    output logic                       mem_we,
    output logic                       mem_wide,
    output logic [OFF_W+SEG_SHIFT-1:0] mem_addr,
    output logic [DATA_W-1:0]          mem_wdata,
    input  logic                       mem_ack,
    input  logic [DATA_W-1:0]          mem_rdata,
    output logic                       busy,
    output logic                       done,
    output logic [OFF_W-1:0]           cx_o,
    output logic [OFF_W-1:0]           si_o,
    output logic [OFF_W-1:0]           di_o,
    output logic [DATA_W-1:0]          acc_o,
    output logic                       zf_o
);

    localparam int ADDR_W = OFF_W + SEG_SHIFT;

    logic              load_cfg;
    logic              dec_cx;
    logic              cap_src;
    logic              cap_dst;
    logic              step_en;
    logic              zf_upd;
    logic              use_src;
    logic              match;
    logic [2:0]        op_q;
    logic [1:0]        rep_q;
    logic              wide_q;
    logic [OFF_W-1:0]  cx_q;
    logic [OFF_W-1:0]  si_q;
    logic [OFF_W-1:0]  di_q;
    logic [OFF_W-1:0]  ds_q;
    logic [OFF_W-1:0]  es_q;
    logic [DATA_W-1:0] acc_q;
    logic              zf_q;
    logic [DATA_W-1:0] src_q;
    logic [DATA_W-1:0] dst_q;
    logic [DATA_W-1:0] cmp_lhs;
    logic [ADDR_W-1:0] src_addr;
    logic [ADDR_W-1:0] dst_addr;

    strx_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .op       (op_q),
        .rep      (rep_q),
        .cx_zero  (cx_q == '0),
        .match    (match),
        .mem_ack  (mem_ack),
        .busy     (busy),
        .done     (done),
        .mem_req  (mem_req),
        .mem_we   (mem_we),
        .use_src  (use_src),
        .load_cfg (load_cfg),
        .dec_cx   (dec_cx),
        .cap_src  (cap_src),
        .cap_dst  (cap_dst),
        .step_en  (step_en),
        .zf_upd   (zf_upd)
    );

    strx_regs #(
        .OFF_W  (OFF_W),
        .DATA_W (DATA_W)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_cfg (load_cfg),
        .op_in    (op_i),
        .rep_in   (rep_i),
        .wide_in  (wide_i),
        .dir_in   (dir_i),
        .cx_in    (cx_i),
        .si_in    (si_i),
        .di_in    (di_i),
        .ds_in    (ds_i),
        .es_in    (es_i),
        .acc_in   (acc_i),
        .zf_in    (zf_i),
        .dec_cx   (dec_cx),
        .step_en  (step_en),
        .cap_src  (cap_src),
        .cap_dst  (cap_dst),
        .zf_upd   (zf_upd),
        .match    (match),
        .rdata    (mem_rdata),
        .op_q     (op_q),
        .rep_q    (rep_q),
        .wide_q   (wide_q),
        .cx_q     (cx_q),
        .si_q     (si_q),
        .di_q     (di_q),
        .ds_q     (ds_q),
        .es_q     (es_q),
        .acc_q    (acc_q),
        .zf_q     (zf_q),
        .src_q    (src_q),
        .dst_q    (dst_q)
    );

    assign cmp_lhs = (op_q == OP_SCAN) ? acc_q : src_q;

    strx_cmp #(
        .DATA_W (DATA_W)
    ) u_cmp (
        .lhs   (cmp_lhs),
        .rhs   (dst_q),
        .wide  (wide_q),
        .match (match)
    );

    assign src_addr  = {ds_q, {SEG_SHIFT{1'b0}}} + {{SEG_SHIFT{1'b0}}, si_q};
    assign dst_addr  = {es_q, {SEG_SHIFT{1'b0}}} + {{SEG_SHIFT{1'b0}}, di_q};
    assign mem_addr  = use_src ? src_addr : dst_addr;
    assign mem_wdata = (op_q == OP_MOVE) ? src_q : acc_q;
    assign mem_wide  = wide_q;

    assign cx_o  = cx_q;
    assign si_o  = si_q;
    assign di_o  = di_q;
    assign acc_o = acc_q;
    assign zf_o  = zf_q;

endmodule

// File: rtl/strx_engine_chk.sv
module strx_engine_chk #(
    parameter int OFF_W     = 16,
    parameter int SEG_SHIFT = 4,
    parameter int DATA_W    = 16
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       mem_req,
    input logic                       mem_we,
    input logic                       mem_wide,
    input logic [OFF_W+SEG_SHIFT-1:0] mem_addr,
    input logic [DATA_W-1:0]          mem_wdata,
    input logic                       mem_ack,
    input logic                       busy,
    input logic                       done,
    input logic [OFF_W-1:0]           cx_o
);

    localparam logic [OFF_W-1:0] ONE = {{(OFF_W-1){1'b0}}, 1'b1};

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req); // R9

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata))); // R9

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R10

    AST_DONE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy); // R10

    AST_CX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ((cx_o == $past(cx_o)) || (cx_o == $past(cx_o) - ONE))); // R6

    AST_WIDTH_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(mem_wide)); // R12

endmodule

bind strx_engine strx_engine_chk #(
    .OFF_W     (OFF_W),
    .SEG_SHIFT (SEG_SHIFT),
    .DATA_W    (DATA_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_wide  (mem_wide),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_ack   (mem_ack),
    .busy      (busy),
    .done      (done),
    .cx_o      (cx_o)
);

// File: tb/strx_engine_bench.sv
module strx_engine_bench;

    localparam int CLK_PERIOD = 10;
    localparam int OFF_W      = 16;
    localparam int SEG_SHIFT  = 4;
    localparam int DATA_W     = 16;
    localparam int ADDR_W     = OFF_W + SEG_SHIFT;
    localparam int MEM_B      = 4096;
    localparam int WDOG       = 150000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [2:0]        op_i = '0;
    logic [1:0]        rep_i = '0;
    logic              wide_i = 1'b0;
    logic              dir_i = 1'b0;
    logic [OFF_W-1:0]  cx_i = '0;
    logic [OFF_W-1:0]  si_i = '0;
    logic [OFF_W-1:0]  di_i = '0;
    logic [OFF_W-1:0]  ds_i = '0;
    logic [OFF_W-1:0]  es_i = '0;
    logic [DATA_W-1:0] acc_i = '0;
    logic              zf_i = 1'b0;
    logic              mem_req;
    logic              mem_we;
    logic              mem_wide;
    logic [ADDR_W-1:0] mem_addr;
    logic [DATA_W-1:0] mem_wdata;
    logic              mem_ack = 1'b0;
    logic [DATA_W-1:0] mem_rdata = '0;
    logic              busy;
    logic              done;
    logic [OFF_W-1:0]  cx_o;
    logic [OFF_W-1:0]  si_o;
    logic [OFF_W-1:0]  di_o;
    logic [DATA_W-1:0] acc_o;
    logic              zf_o;

    strx_engine #(
        .OFF_W     (OFF_W),
        .SEG_SHIFT (SEG_SHIFT),
        .DATA_W    (DATA_W)
    ) u_strx_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .op_i      (op_i),
        .rep_i     (rep_i),
        .wide_i    (wide_i),
        .dir_i     (dir_i),
        .cx_i      (cx_i),
        .si_i      (si_i),
        .di_i      (di_i),
        .ds_i      (ds_i),
        .es_i      (es_i),
        .acc_i     (acc_i),
        .zf_i      (zf_i),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_wide  (mem_wide),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_ack   (mem_ack),
        .mem_rdata (mem_rdata),
        .busy      (busy),
        .done      (done),
        .cx_o      (cx_o),
        .si_o      (si_o),
        .di_o      (di_o),
        .acc_o     (acc_o),
        .zf_o      (zf_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    logic [7:0] mem  [MEM_B];
    logic [7:0] mref [MEM_B];
    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    int lat = 0;
    int wcnt = 0;
    int acc_idx;
    string cur_tag = "";

    int q_addr[$];
    int q_we[$];
    int q_wide[$];
    int q_wdata[$];

    int e_cx, e_si, e_di, e_acc, e_zf;

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > WDOG) begin
            n_chk++;
            n_bad++;
            $display("FAIL R9 watchdog: actual=%0d expected=<%0d", cyc, WDOG);
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    // memory responder with adjustable latency; every access matched to the reference
    always @(negedge clk) begin
        if (!rst_n || !mem_req) begin
            mem_ack = 1'b0;
            wcnt = 0;
        end else if (wcnt >= lat) begin
            acc_idx = int'(mem_addr) % MEM_B;
            if (q_addr.size() == 0) begin
                chk("R9", {cur_tag, " unexpected access"}, 64'(mem_addr), 64'hFFFFFFFF);
            end else begin
                chk("R2", {cur_tag, " address"}, 64'(mem_addr), 64'(q_addr.pop_front()));
                chk("R4", {cur_tag, " write enable"}, 64'(mem_we), 64'(q_we.pop_front()));
                chk("R12", {cur_tag, " width"}, 64'(mem_wide), 64'(q_wide.pop_front()));
                if (q_we.size() >= 0 && mem_we) begin
                    chk("R4", {cur_tag, " write data"},
                        64'(mem_wide ? mem_wdata : {8'h00, mem_wdata[7:0]}), 64'(q_wdata.pop_front()));
                end else begin
                    void'(q_wdata.pop_front());
                end
            end
            if (mem_we) begin
                mem[acc_idx] = mem_wdata[7:0];
                if (mem_wide) mem[(acc_idx + 1) % MEM_B] = mem_wdata[15:8];
            end
            if (mem_wide) mem_rdata = {mem[(acc_idx + 1) % MEM_B], mem[acc_idx]};
            else          mem_rdata = {~mem[acc_idx], mem[acc_idx]};
            mem_ack = 1'b1;
            wcnt = 0;
        end else begin
            mem_ack = 1'b0;
            wcnt++;
        end
    end

    function automatic int mrd(input int a, input bit w);
        int lo;
        int hi;
        lo = int'(mref[a % MEM_B]);
        hi = w ? int'(mref[(a + 1) % MEM_B]) : 0;
        return (hi << 8) | lo;
    endfunction

    task automatic mwr(input int a, input bit w, input int v);
        mref[a % MEM_B] = 8'(v);
        if (w) mref[(a + 1) % MEM_B] = 8'(v >> 8);
    endtask

    task automatic push_acc(input int a, input int we, input bit w, input int v);
        q_addr.push_back(a);
        q_we.push_back(we);
        q_wide.push_back(int'(w));
        q_wdata.push_back(w ? (v & 'hFFFF) : (v & 'hFF));
    endtask

    // behavioural reference: expected accesses and final values
    task automatic model(input int op, input int rep, input bit w, input bit dir,
                         input int cx, input int si, input int di, input int ds, input int es,
                         input int acc, input bit zf);
        int stride;
        int sa;
        int da;
        int s;
        int d;
        stride = w ? 2 : 1;
        q_addr.delete(); q_we.delete(); q_wide.delete(); q_wdata.delete();
        e_cx = cx; e_si = si; e_di = di; e_acc = acc; e_zf = int'(zf);
        if (op > 4) return;
        forever begin
            if (rep != 0 && e_cx == 0) break;
            if (rep != 0) e_cx = e_cx - 1;
            sa = ((ds << 4) + e_si) & 'hFFFFF;
            da = ((es << 4) + e_di) & 'hFFFFF;
            case (op)
                0: begin
                    s = mrd(sa, w);
                    push_acc(sa, 0, w, 0);
                    push_acc(da, 1, w, s);
                    mwr(da, w, s);
                end
                1: begin
                    s = mrd(sa, w);
                    push_acc(sa, 0, w, 0);
                    d = mrd(da, w);
                    push_acc(da, 0, w, 0);
                    e_zf = (s == d) ? 1 : 0;
                end
                2: begin
                    d = mrd(da, w);
                    push_acc(da, 0, w, 0);
                    e_zf = (((w ? e_acc : (e_acc & 'hFF)) & 'hFFFF) == d) ? 1 : 0;
                end
                3: begin
                    s = mrd(sa, w);
                    push_acc(sa, 0, w, 0);
                    e_acc = w ? s : ((e_acc & 'hFF00) | s);
                end
                default: begin
                    push_acc(da, 1, w, e_acc);
                    mwr(da, w, e_acc);
                end
            endcase
            if (op == 0 || op == 1 || op == 3) e_si = (dir ? e_si - stride : e_si + stride) & 'hFFFF;
            if (op != 3) e_di = (dir ? e_di - stride : e_di + stride) & 'hFFFF;
            if (rep == 0) break;
            if ((op == 1 || op == 2) && rep == 2 && e_zf == 0) break;
            if ((op == 1 || op == 2) && rep == 3 && e_zf == 1) break;
        end
    endtask

    task automatic run(input string tag, input int op, input int rep, input bit w, input bit dir,
                       input int cx, input int si, input int di, input int ds, input int es,
                       input int acc, input bit zf, input int latency, input int exp_lat,
                       input bit poke);
        int n;
        mref = mem;
        model(op, rep, w, dir, cx, si, di, ds, es, acc, zf);
        cur_tag = tag;
        lat = latency;
        @(negedge clk);
        op_i = 3'(op); rep_i = 2'(rep); wide_i = w; dir_i = dir;
        cx_i = 16'(cx); si_i = 16'(si); di_i = 16'(di); ds_i = 16'(ds); es_i = 16'(es);
        acc_i = 16'(acc); zf_i = zf;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        n = 1;
        while (!done && n < 3000) begin
            @(negedge clk);
            n++;
            if (poke && n == 3) begin
                // R11: a second start while busy with different operands
                start = 1'b1; op_i = 3'd4; cx_i = 16'd9; di_i = 16'h0555; acc_i = 16'hDEAD;
            end
            if (poke && n == 4) start = 1'b0;
        end
        chk("R10", {tag, " done seen"}, 64'(done), 64'd1);
        if (exp_lat >= 0) chk("R6", {tag, " done latency"}, 64'(n), 64'(exp_lat));
        chk("R9", {tag, " accesses left over"}, 64'(q_addr.size()), 64'd0);
        chk("R6", {tag, " count"}, 64'(cx_o), 64'(e_cx));
        chk("R3", {tag, " source offset"}, 64'(si_o), 64'(e_si));
        chk("R3", {tag, " destination offset"}, 64'(di_o), 64'(e_di));
        chk("R4", {tag, " accumulator"}, 64'(acc_o), 64'(e_acc));
        chk("R8", {tag, " zero flag"}, 64'(zf_o), 64'(e_zf));
        @(negedge clk);
        chk("R10", {tag, " done one cycle"}, 64'(done), 64'd0);
        chk("R10", {tag, " idle after"}, 64'(busy), 64'd0);
        chk("R10", {tag, " count held"}, 64'(cx_o), 64'(e_cx));
    endtask

    initial begin
        for (int i = 0; i < MEM_B; i++) mem[i] = 8'((i * 7 + 3) ^ (i >> 4));
        repeat (3) @(negedge clk);
        chk("R1", "busy after reset", 64'(busy), 64'd0);
        chk("R1", "done after reset", 64'(done), 64'd0);
        chk("R1", "mem_req after reset", 64'(mem_req), 64'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // compare strings: equal for 5 bytes, differ at the sixth
        for (int i = 0; i < 9; i++) begin
            mem[12'h300 + i] = 8'(8'h41 + i);
            mem[12'h600 + i] = (i == 5) ? 8'h7E : 8'(8'h41 + i);
        end
        // word target for the scan
        mem[12'h41A] = 8'h34;
        mem[12'h41B] = 8'h12;

        run("R6 copy bytes up",          0, 1, 0, 0, 5, 'h0000, 'h0100, 'h10, 'h40, 0, 0, 0, -1, 0);
        run("R3 copy words down",        0, 1, 1, 1, 3, 'h0030, 'h0060, 'h10, 'h40, 0, 1, 1, -1, 0);
        run("R7 compare while equal",    1, 2, 0, 0, 9, 'h0200, 'h0200, 'h10, 'h40, 0, 1, 2, -1, 0);
        run("R7 compare while differ",   1, 3, 1, 0, 4, 'h0200, 'h0200, 'h10, 'h40, 0, 0, 0, -1, 0);
        run("R7 scan while differ word", 2, 3, 1, 1, 8, 'h0000, 'h0020, 'h10, 'h40, 'h1234, 0, 1, -1, 0);
        run("R7 scan while equal byte",  2, 2, 0, 0, 6, 'h0000, 'h0200, 'h10, 'h40, 'h5541, 0, 0, -1, 0);
        run("R5 single byte load",       3, 0, 0, 0, 7, 'h0205, 'h0000, 'h10, 'h40, 'hAB00, 1, 2, -1, 0);
        run("R5 single word load",       3, 0, 1, 0, 2, 'h0204, 'h0000, 'h10, 'h40, 'h0000, 0, 0, -1, 0);
        run("R3 store words down",       4, 1, 1, 1, 4, 'h0000, 'h0080, 'h10, 'h40, 'hC3A5, 0, 1, -1, 0);
        run("R6 zero count",             0, 1, 0, 0, 0, 'h0011, 'h0022, 'h10, 'h40, 'h0101, 1, 0, 2, 0);
        run("R4 reserved code",          6, 1, 1, 0, 3, 'h0011, 'h0022, 'h10, 'h40, 'h0202, 0, 0, 2, 0);
        run("R8 copy ignores while-eq",  0, 2, 0, 0, 3, 'h0040, 'h0140, 'h10, 'h40, 0, 0, 1, -1, 0);
        run("R8 compare word single",    1, 0, 1, 0, 5, 'h0200, 'h0200, 'h10, 'h40, 0, 0, 0, -1, 0);
        run("R2 offset wrap load",       3, 0, 1, 1, 1, 'h0000, 'h0000, 'h10, 'h40, 0, 0, 1, -1, 0);
        run("R2 offset wrap store",      4, 1, 0, 0, 3, 'h0000, 'hFFFE, 'h10, 'h40, 'h005A, 0, 0, -1, 0);
        run("R2 address wrap copy",      0, 0, 0, 0, 1, 'h0020, 'h0300, 'hFFFF, 'h40, 0, 0, 2, -1, 0);
        run("R11 start while busy",      0, 1, 1, 0, 4, 'h0050, 'h0150, 'h10, 'h40, 0, 0, 2, -1, 1);
        run("R12 byte store after",      4, 0, 0, 1, 1, 'h0000, 'h0700, 'h10, 'h40, 'hBEEF, 0, 0, -1, 0);

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule